// File: doc/BRIEF.md
# Register-Programmed Watchdog Timer

This block is a watchdog with two byte-wide registers. The control register at offset 0 selects the count unit and holds a sticky timeout flag. The count register at offset 1 holds the number of units to count. Writing a nonzero count arms the timer. Writing the count again before it expires reloads the countdown, which is how software services the watchdog. Writing zero disarms it. When the countdown runs out, the block sets the flag, drives a one-clock timeout pulse, and stays idle until the count register is written again.

The time bases come from a slow tick input. A chain of three dividers turns the tick into 10 ms, 1 s and 1 min strobes. The parameter `TICKS_PER_10MS` sets how many ticks make up 10 ms, so simulation can use a very short period. The dividers restart on every count write, so the first unit after a write is always a full interval. A strap input selects the power-on contents of both registers. With the strap high, the watchdog comes out of reset already armed for ten seconds.

Top module: `wdog_top`

## Requirements
- R1: Reading offset 0 returns {5'b0, unit[1:0], flag}, so bits [7:3] always read 0. Reading offset 1 returns the last value written to the count register. Reads are combinational from `addr_i`.
- R2: The unit codes are 00 = 10 ms (`TICKS_PER_10MS` ticks), 01 = 1 s (100 × 10 ms) and 10 = 1 min (60 × 1 s). For a write of count N on clock edge E with `tick_i` high every cycle, `expired_o` is high in the cycle after edge E + N × (ticks per unit).
- R3: Writing a nonzero value to offset 1 arms the timer. The unit dividers restart on that write, so the first unit is a full interval.
- R4: Writing 0 to offset 1 disarms the timer, and no timeout follows.
- R5: Writing a nonzero count while the timer is armed reloads the countdown, and the timing restarts from that write.
- R6: On expiry, `expired_o` is high for exactly one cycle and the flag (offset 0 bit 0) becomes 1 on the next edge. Counting then stops until offset 1 is written again.
- R7: Writing offset 0 with bit 0 = 1 clears the flag, and writing it with bit 0 = 0 leaves the flag unchanged. If an expiry and a clearing write land on the same edge, the flag ends up set.
- R8: Unit code 11 stops counting but keeps the remaining count. The dividers keep running, and counting resumes once a valid unit is written.
- R9: On the first edge after reset is released, the registers load defaults chosen by `strap_i`. With the strap low both registers are 0x00. With the strap high the control register is 0x02 and the count is 0x0A, and the timer is armed from that edge.
- R10: The dividers advance only in cycles where `tick_i` is high. With no ticks, no unit elapses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_i | input | 1 | Selects the power-on register defaults |
| tick_i | input | 1 | Slow time-base tick, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register offset (0 = control, 1 = count) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| expired_o | output | 1 | One-cycle timeout pulse |

## Verification
The hardest case to reach is a clearing write to the control register that lands on the same edge as the flag being set by an expiry. The stimulus arms a one-unit countdown on the shortest unit with `tick_i` held high, so the expiry edge is known exactly, and it schedules the clearing write for that edge. The bench then checks that the flag is still set. The second hard case is a switch to the reserved unit partway through a countdown. The stimulus switches to the reserved unit and back across a known 1 s strobe edge, and it checks that the expiry is delayed by exactly one unit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CNT  = 1'b1;

  typedef enum logic [1:0] {
    UNIT_10MS = 2'b00,
    UNIT_1S   = 2'b01,
    UNIT_1MIN = 2'b10,
    UNIT_HALT = 2'b11
  } unit_e;

  localparam logic [7:0] STRAP_CNT_DEF = 8'h0A;
endpackage

// File: rtl/wdog_div.sv
module wdog_div #(
  parameter int DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic wrap_o
);
  localparam int W = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (step_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assert_hold_without_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strap_i,
  input  logic       wr_en_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  input  logic       expire_i,
  output logic [7:0] rdata_o,
  output unit_e      unit_o,
  output logic       load_o,
  output logic [7:0] load_val_o
);
  logic       init_q;
  unit_e      unit_q;
  logic [7:0] cnt_reg_q;
  logic       flag_q;

  logic wr_ctrl, wr_cnt;
  assign wr_ctrl = init_q && wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_cnt  = init_q && wr_en_i && (addr_i == ADDR_CNT);

  // first edge after reset loads strap-selected defaults
  assign load_o     = !init_q || wr_cnt;
  assign load_val_o = !init_q ? (strap_i ? STRAP_CNT_DEF : 8'h00) : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q    <= 1'b0;
      unit_q    <= UNIT_10MS;
      cnt_reg_q <= '0;
      flag_q    <= 1'b0;
    end else begin
      init_q <= 1'b1;
      if (!init_q) begin
        unit_q    <= strap_i ? UNIT_1S : UNIT_10MS;
        cnt_reg_q <= load_val_o;
      end else begin
        if (wr_ctrl) unit_q <= unit_e'(wdata_i[2:1]);
        if (wr_cnt)  cnt_reg_q <= wdata_i;
      end
      if (expire_i)                    flag_q <= 1'b1;
      else if (wr_ctrl && wdata_i[0])  flag_q <= 1'b0;
    end
  end

  always_comb begin
    if (addr_i == ADDR_CTRL) rdata_o = {5'b0, unit_q, flag_q};
    else                     rdata_o = cnt_reg_q;
  end

  assign unit_o = unit_q;

  assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> flag_q);
  assert_flag_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && wdata_i[0] && !expire_i) |=> !flag_q);
  assert_flag_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_ctrl && wdata_i[0])) |=> flag_q);
  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_CTRL) |-> (rdata_o[7:3] == 5'b0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          unit_strobe_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_val_i;
      end else if (unit_strobe_i && (cnt_q != '0)) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) exp_q <= 1'b1;
      end
    end
  end

  assign expire_o = exp_q;

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q |=> !exp_q);
  assert_load_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  assert_idle_stays_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0 && !exp_q));
  assert_no_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int TICKS_PER_10MS = 10000,
  parameter int HUND_PER_S     = 100,
  parameter int S_PER_MIN      = 60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strap_i,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       expired_o
);
  localparam int NSTAGE = 3;

  function automatic int stage_div(input int idx);
    case (idx)
      0:       return TICKS_PER_10MS;
      1:       return HUND_PER_S;
      default: return S_PER_MIN;
    endcase
  endfunction

  unit_e       unit;
  logic        load;
  logic [7:0]  load_val;
  logic [NSTAGE-1:0] strobe;
  logic        unit_strobe;

  wdog_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strap_i    (strap_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .expire_i   (expired_o),
    .rdata_o    (rdata_o),
    .unit_o     (unit),
    .load_o     (load),
    .load_val_o (load_val)
  );

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    logic step;
    if (g == 0) begin : g_first
      assign step = tick_i;
    end else begin : g_next
      assign step = strobe[g-1];
    end
    wdog_div #(.DIV(stage_div(g))) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (load),
      .step_i  (step),
      .wrap_o  (strobe[g])
    );
  end

  always_comb begin
    case (unit)
      UNIT_10MS: unit_strobe = strobe[0];
      UNIT_1S:   unit_strobe = strobe[1];
      UNIT_1MIN: unit_strobe = strobe[2];
      default:   unit_strobe = 1'b0;
    endcase
  end

  wdog_counter #(.CW(8)) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load),
    .load_val_i    (load_val),
    .unit_strobe_i (unit_strobe),
    .expire_o      (expired_o)
  );

  assert_halt_unit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit == UNIT_HALT && !load) |=> !expired_o);
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  localparam int T10 = 2;
  localparam int U_10MS = T10;
  localparam int U_1S   = T10 * 100;
  localparam int U_1MIN = T10 * 6000;

  logic clk = 0, rst_n = 0, strap = 0, tick = 1, wr_en = 0, addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic expired;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  wdog_top #(.TICKS_PER_10MS(T10)) dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .tick_i(tick),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .expired_o(expired)
  );

  function automatic logic [7:0] ctrl_exp(input logic [1:0] u, input logic f);
    return {5'b0, u, f};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  // returns cycles from the write edge to the expiry pulse, -1 if none
  task automatic wait_exp(input int limit, output int k);
    k = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (expired) begin k = i; break; end
    end
  endtask

  task automatic do_reset(input logic s);
    rst_n = 0; strap = s; wr_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic fin();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    fin();
  end

  initial begin
    logic [7:0] d;
    int k;
    logic flag_m;
    logic [1:0] unit_m;
    logic [7:0] cnt_m;
    void'($urandom(32'h5eed));

    // R9 strap low defaults
    do_reset(0);
    @(negedge clk); @(negedge clk);
    rd(0, d); chk("R9 ctrl default", d, 8'h00);
    rd(1, d); chk("R9 count default", d, 8'h00);
    chk("R9 no pulse", expired, 0);
    wait_exp(50, k); chk("R4 idle no expiry", k, -1);

    // R2/R3 10 ms unit
    wr(0, 8'h00); wr(1, 8'd5);
    wait_exp(100, k); chk("R2 10ms N=5", k, 5 * U_10MS);
    @(negedge clk); chk("R6 pulse one cycle", expired, 0);
    wait_exp(60, k); chk("R6 stops after expiry", k, -1);
    rd(0, d); chk("R6 flag set", d, ctrl_exp(2'b00, 1));
    rd(1, d); chk("R1 count readback", d, 8'd5);

    // R7 write 0 keeps, write 1 clears
    wr(0, 8'h00); rd(0, d); chk("R7 write0 keeps flag", d, ctrl_exp(2'b00, 1));
    wr(0, 8'hF9); rd(0, d); chk("R7 w1c clears, R1 rsvd zero", d, ctrl_exp(2'b00, 0));

    // R2 1 s unit
    wr(0, 8'h02); wr(1, 8'd2);
    wait_exp(1000, k); chk("R2 1s N=2", k, 2 * U_1S);
    wr(0, 8'h03);

    // R2 1 min unit
    wr(0, 8'h04); wr(1, 8'd1);
    wait_exp(13000, k); chk("R2 1min N=1", k, U_1MIN);
    wr(0, 8'h05);

    // R3 random counts on 10 ms unit
    wr(0, 8'h00);
    for (int it = 0; it < 8; it++) begin
      int n;
      n = $urandom_range(1, 60);
      wr(1, 8'(n));
      wait_exp(200, k); chk("R3 random count", k, n * U_10MS);
    end
    wr(0, 8'h01);

    // R5 reload while armed
    wr(1, 8'd2);
    @(negedge clk); @(negedge clk);
    wr(1, 8'd2);
    wait_exp(50, k); chk("R5 reload restarts", k, 2 * U_10MS);

    // R4 disable
    wr(1, 8'd3);
    wr(1, 8'd0);
    wait_exp(100, k); chk("R4 zero disables", k, -1);

    // R10 no ticks, no progress
    tick = 0;
    wr(1, 8'd1);
    wait_exp(50, k); chk("R10 no tick no expiry", k, -1);
    tick = 1;
    wait_exp(20, k); chk("R10 resume on tick", k, U_10MS);
    wr(0, 8'h01);

    // R7 expiry and clear on the same edge: set wins
    wr(1, 8'd1);
    @(negedge clk);
    @(negedge clk); chk("R7 race pulse", expired, 1);
    wr_en = 1; addr = 0; wdata = 8'h01;
    @(negedge clk); wr_en = 0;
    rd(0, d); chk("R7 set wins over clear", d, ctrl_exp(2'b00, 1));
    wr(0, 8'h01);

    // R8 reserved unit halts across the 1 s strobe at edge 400
    wr(0, 8'h02); wr(1, 8'd3);
    k = -1;
    for (int i = 1; i <= 1200; i++) begin
      @(negedge clk);
      wr_en = 0;
      if (expired && k < 0) k = i;
      if (i == 250) begin wr_en = 1; addr = 0; wdata = 8'h06; end
      if (i == 450) begin wr_en = 1; addr = 0; wdata = 8'h02; end
    end
    chk("R8 halt keeps remaining count", k, 800);
    wr(0, 8'h03);

    // R1 random register traffic, ticks off
    tick = 0;
    flag_m = 0; unit_m = 2'b01; cnt_m = 8'd3;
    for (int it = 0; it < 30; it++) begin
      logic a;
      logic [7:0] v;
      a = 1'($urandom);
      v = 8'($urandom);
      wr(a, v);
      if (a) cnt_m = v;
      else begin unit_m = v[2:1]; if (v[0]) flag_m = 0; end
      rd(0, d); chk("R1 ctrl readback", d, ctrl_exp(unit_m, flag_m));
      rd(1, d); chk("R1 count readback", d, cnt_m);
    end
    wr(1, 8'd0);
    tick = 1;

    // R9 strap high: armed 10 x 1 s from first edge after reset
    do_reset(1);
    k = -1;
    for (int i = 1; i <= 2100; i++) begin
      @(negedge clk);
      if (i == 2) begin
        rd(0, d); chk("R9 strap ctrl", d, 8'h02);
        rd(1, d); chk("R9 strap count", d, 8'h0A);
      end
      if (expired && k < 0) k = i;
    end
    chk("R9 strap armed expiry", k, 1 + 10 * U_1S);

    fin();
  end
endmodule